// File: doc/BRIEF.md
# Programmable Bidirectional Pin Cell

This block sits between a programmable logic array and one three-state pad. The pad is modelled as three separate signals: the value seen on the pin, the value to drive and the driver enable. A 3-bit mode field sets what the cell does with the pin:

- pass the pin straight through as an input;
- capture the pin in an edge-triggered register or in a level-sensitive latch;
- drive the pin as an output at all times;
- use the pin in both directions, with the array deciding when the driver is on.

The value sent to the pin can be inverted by a polarity control, so the array always works in active-high terms.

The input register and the latch both run from an I/O clock. The cell chooses that clock from two I/O clock lines. Either line may come from a dedicated clock pin or from a clock made inside the array. An active-low global reset clears the captured input at once, with no clock needed. In bidirectional mode the input path looks at the pad itself. When the driver is on, the array therefore reads back the value the cell is driving.

Top module: `pio_cell`

## Requirements
- R1: The mode field `mode` encodes 0 = pass-through input, 1 = registered input, 2 = latched input, 3 = output-only, 4 = bidirectional. The codes 5, 6 and 7 behave exactly as code 0.
- R2: In pass-through input mode, `arr_in` equals `pad_in` combinationally, with no clock edge needed.
- R3: In registered input mode, `arr_in` takes the value of `pad_in` at each rising edge of the selected I/O clock. Between those edges it holds, whatever `pad_in` does.
- R4: In latched input mode, `arr_in` follows `pad_in` while the selected I/O clock is high. While that clock is low, it holds the value it had when the clock fell.
- R5: `clk_sel` = 0 selects `io_clk0` and `clk_sel` = 1 selects `io_clk1`. Edges on the line that is not selected do not change the captured input.
- R6: While `rst_n` is low, the input register and the latch are cleared to 0 at once, without a clock. `arr_in` therefore reads 0 in registered and latched modes.
- R7: In every input-only mode (codes 0, 1, 2, 5, 6, 7), `pad_oe` is 0 whatever `arr_oe` is.
- R8: In output-only mode (code 3), `pad_oe` is 1 whatever `arr_oe` is, and `arr_in` reads 0.
- R9: In bidirectional mode (code 4), `pad_oe` equals `arr_oe`, and `arr_in` equals `pad_in` combinationally.
- R10: In every mode, `pad_out` equals `arr_out` when `inv_out` = 0 and equals the inverse of `arr_out` when `inv_out` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Global reset, active low, asynchronous; clears the input register and the latch |
| io_clk0 | input | 1 | First I/O clock line |
| io_clk1 | input | 1 | Second I/O clock line |
| clk_sel | input | 1 | I/O clock choice: 0 = io_clk0, 1 = io_clk1 |
| mode | input | 3 | Cell mode code (see R1) |
| inv_out | input | 1 | Output polarity: 1 inverts the value sent to the pad |
| arr_out | input | 1 | Value from the array to be sent to the pad |
| arr_oe | input | 1 | Driver enable from the array (used in bidirectional mode) |
| pad_in | input | 1 | Value currently seen on the pad |
| pad_out | output | 1 | Value to drive onto the pad |
| pad_oe | output | 1 | Pad driver enable |
| arr_in | output | 1 | Input value delivered to the array |

## Verification
The hardest behaviour to reach from the ports is the latch and the register holding their value while the pin changes. The bench has to change `pad_in` at exact points in the selected clock's phase: after the rising edge for the register, and after the falling edge for the latch. It then reads `arr_in` before the next edge.

The clock-select behaviour needs one clock line to stay quiet while the other keeps running. The bench can therefore stop the second line on demand. While that line is stopped, the pin changes and the first line keeps toggling, and the bench checks that nothing is captured until the second line runs again.

All eight mode codes are swept against both clock choices, both polarities and every combination of the array's value and driver enable.

// File: rtl/pio_pkg.sv
package pio_pkg;

  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    PM_COMB  = 3'd0,
    PM_REG   = 3'd1,
    PM_LAT   = 3'd2,
    PM_OUT   = 3'd3,
    PM_BIDIR = 3'd4
  } pio_mode_e;

  typedef enum logic [1:0] {
    SRC_PIN  = 2'd0,
    SRC_REG  = 2'd1,
    SRC_LAT  = 2'd2,
    SRC_ZERO = 2'd3
  } in_src_e;

  typedef struct packed {
    in_src_e src;
    logic    drv_always;
    logic    drv_gated;
  } pio_ctl_t;

  // Mode code to control word; unused codes fall back to pass-through input.
  function automatic pio_ctl_t pio_decode(input logic [MODE_W-1:0] m);
    pio_ctl_t c;
    c.src        = SRC_PIN;
    c.drv_always = 1'b0;
    c.drv_gated  = 1'b0;
    case (m)
      PM_REG:   c.src = SRC_REG;
      PM_LAT:   c.src = SRC_LAT;
      PM_OUT: begin
        c.src        = SRC_ZERO;
        c.drv_always = 1'b1;
      end
      PM_BIDIR: c.drv_gated = 1'b1;
      default:  c.src = SRC_PIN;
    endcase
    return c;
  endfunction

  function automatic logic pio_polar(input logic d, input logic inv);
    return d ^ inv;
  endfunction

  function automatic logic pio_enable(input logic always_on, input logic gated,
                                      input logic oe);
    return always_on | (gated & oe);
  endfunction

endpackage

// File: rtl/pio_mode_dec.sv
module pio_mode_dec
  import pio_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  output pio_ctl_t          ctl
);
  always_comb ctl = pio_decode(mode);
endmodule

// File: rtl/pio_in_path.sv
module pio_in_path
  import pio_pkg::*;
#(
  parameter logic RST_VAL = 1'b0
) (
  input  logic    sel_clk,
  input  logic    rst_n,
  input  logic    pad_in,
  input  in_src_e src,
  output logic    arr_in
);
  logic q_reg;
  logic q_lat;

  always_ff @(posedge sel_clk or negedge rst_n) begin
    if (!rst_n) q_reg <= RST_VAL;
    else        q_reg <= pad_in;
  end

  always_latch begin
    if (!rst_n)       q_lat <= RST_VAL;
    else if (sel_clk) q_lat <= pad_in;
  end

  always_comb begin
    case (src)
      SRC_REG:  arr_in = q_reg;
      SRC_LAT:  arr_in = q_lat;
      SRC_ZERO: arr_in = 1'b0;
      default:  arr_in = pad_in;
    endcase
  end
endmodule

// File: rtl/pio_out_path.sv
module pio_out_path
  import pio_pkg::*;
(
  input  logic arr_out,
  input  logic arr_oe,
  input  logic inv_out,
  input  logic drv_always,
  input  logic drv_gated,
  output logic pad_out,
  output logic pad_oe
);
  always_comb begin
    pad_out = pio_polar(arr_out, inv_out);
    pad_oe  = pio_enable(drv_always, drv_gated, arr_oe);
  end
endmodule

// File: rtl/pio_cell.sv
module pio_cell
  import pio_pkg::*;
#(
  parameter logic RST_VAL = 1'b0
) (
  input  logic              rst_n,
  input  logic              io_clk0,
  input  logic              io_clk1,
  input  logic              clk_sel,
  input  logic [MODE_W-1:0] mode,
  input  logic              inv_out,
  input  logic              arr_out,
  input  logic              arr_oe,
  input  logic              pad_in,
  output logic              pad_out,
  output logic              pad_oe,
  output logic              arr_in
);
  pio_ctl_t ctl;
  logic     sel_clk;

  assign sel_clk = clk_sel ? io_clk1 : io_clk0;

  pio_mode_dec u_dec (
    .mode (mode),
    .ctl  (ctl)
  );

  pio_in_path #(.RST_VAL(RST_VAL)) u_in (
    .sel_clk (sel_clk),
    .rst_n   (rst_n),
    .pad_in  (pad_in),
    .src     (ctl.src),
    .arr_in  (arr_in)
  );

  pio_out_path u_out (
    .arr_out    (arr_out),
    .arr_oe     (arr_oe),
    .inv_out    (inv_out),
    .drv_always (ctl.drv_always),
    .drv_gated  (ctl.drv_gated),
    .pad_out    (pad_out),
    .pad_oe     (pad_oe)
  );
endmodule

// File: rtl/pio_cell_chk.sv
module pio_cell_chk (
  input logic       rst_n,
  input logic       sel_clk,
  input logic [2:0] mode,
  input logic       inv_out,
  input logic       arr_out,
  input logic       arr_oe,
  input logic       pad_in,
  input logic       pad_out,
  input logic       pad_oe,
  input logic       arr_in
);
  logic in_only, is_reg, is_lat, is_pin;
  assign in_only = (mode != 3'd3) && (mode != 3'd4);
  assign is_reg  = (mode == 3'd1);
  assign is_lat  = (mode == 3'd2);
  assign is_pin  = (mode == 3'd0) || (mode >= 3'd5) || (mode == 3'd4);

  // R7
  assert_inonly_hiz_R7: assert property (@(posedge sel_clk) disable iff (!rst_n)
    in_only |-> !pad_oe);
  // R8
  assert_outmode_drive_R8: assert property (@(posedge sel_clk) disable iff (!rst_n)
    (mode == 3'd3) |-> (pad_oe && !arr_in));
  // R9
  assert_bidir_oe_R9: assert property (@(posedge sel_clk) disable iff (!rst_n)
    (mode == 3'd4) |-> (pad_oe == arr_oe));
  // R10
  assert_polarity_R10: assert property (@(posedge sel_clk) disable iff (!rst_n)
    pad_out == (inv_out ? !arr_out : arr_out));
  // R2 / R1: pass-through codes deliver the pin
  assert_passthru_R2: assert property (@(posedge sel_clk) disable iff (!rst_n)
    is_pin |-> (arr_in == pad_in));
  // R3
  assert_reg_capture_R3: assert property (@(posedge sel_clk) disable iff (!rst_n)
    is_reg |=> (!is_reg || arr_in == $past(pad_in)));
  // R4
  assert_latch_follow_R4: assert property (@(negedge sel_clk) disable iff (!rst_n)
    is_lat |-> (arr_in == pad_in));
endmodule

bind pio_cell pio_cell_chk u_chk (
  .rst_n   (rst_n),
  .sel_clk (sel_clk),
  .mode    (mode),
  .inv_out (inv_out),
  .arr_out (arr_out),
  .arr_oe  (arr_oe),
  .pad_in  (pad_in),
  .pad_out (pad_out),
  .pad_oe  (pad_oe),
  .arr_in  (arr_in)
);

// File: tb/tb_pio_cell.sv
`timescale 1ns/1ps
module tb_pio_cell;
  logic       clk = 1'b0;
  logic       io_clk1 = 1'b0;
  logic       c1_run = 1'b1;
  logic       rst_n = 1'b0;
  logic       clk_sel = 1'b0;
  logic [2:0] mode = 3'd1;
  logic       inv_out = 1'b0;
  logic       arr_out = 1'b0;
  logic       arr_oe = 1'b0;
  logic       pad_in = 1'b0;
  logic       pad_out, pad_oe, arr_in;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) io_clk1 <= c1_run ? ~io_clk1 : 1'b0;

  pio_cell dut (
    .rst_n(rst_n), .io_clk0(clk), .io_clk1(io_clk1), .clk_sel(clk_sel),
    .mode(mode), .inv_out(inv_out), .arr_out(arr_out), .arr_oe(arr_oe),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .arr_in(arr_in)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s mode=%0d sel=%0d: actual %b expected %b",
               req, mode, clk_sel, act, exp);
    end
  endtask

  task automatic wpos(input logic s);
    if (s) @(posedge io_clk1); else @(posedge clk);
  endtask
  task automatic wneg(input logic s);
    if (s) @(negedge io_clk1); else @(negedge clk);
  endtask

  // kind: 0 pin, 1 reg, 2 latch, 3 out, 4 bidir
  function automatic int kind_of(input int m);
    if (m == 1) return 1;
    if (m == 2) return 2;
    if (m == 3) return 3;
    if (m == 4) return 4;
    return 0;
  endfunction

  function automatic string tag_of(input int k, input int m);
    if (m >= 5) return "R1";
    case (k)
      1: return "R3";
      2: return "R4";
      3: return "R8";
      4: return "R9";
      default: return "R2";
    endcase
  endfunction

  initial begin
    #(2_000_000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // reset state, R6
    pad_in = 1'b1;
    repeat (3) @(posedge clk);
    #1 chk("R6 reset holds register", arr_in, 1'b0);
    @(negedge clk); rst_n = 1'b1;

    // sweep
    for (int m = 0; m < 8; m++)
      for (int s = 0; s < 2; s++)
        for (int iv = 0; iv < 2; iv++)
          for (int oe = 0; oe < 2; oe++)
            for (int ao = 0; ao < 2; ao++) begin
              int    k;
              string t;
              logic  eoe;
              k = kind_of(m);
              t = tag_of(k, m);
              wneg(s[0]); #1;
              mode = m[2:0]; clk_sel = s[0]; inv_out = iv[0];
              arr_oe = oe[0]; arr_out = ao[0];
              #1 pad_in = 1'b0;
              wpos(s[0]); wpos(s[0]); #1;
              eoe = (k == 3) ? 1'b1 : (k == 4) ? oe[0] : 1'b0;
              chk((k == 3) ? "R8 oe" : (k == 4) ? "R9 oe" : "R7 oe", pad_oe, eoe);
              chk("R10 polarity", pad_out, ao[0] ^ iv[0]);
              chk({t, " settle 0"}, arr_in, 1'b0);
              pad_in = 1'b1; #1;
              chk({t, " high phase"}, arr_in,
                  (k == 0 || k == 4 || k == 2) ? 1'b1 : 1'b0);
              wneg(s[0]); #1;
              pad_in = 1'b0; #1;
              chk({t, " low phase hold"}, arr_in, (k == 2) ? 1'b1 : 1'b0);
              pad_in = 1'b1;
              wpos(s[0]); #1;
              chk({t, " after edge"}, arr_in, (k == 3) ? 1'b0 : 1'b1);
            end

    // R5: unselected line edges do nothing
    @(negedge clk); #1;
    mode = 3'd1; clk_sel = 1'b1; c1_run = 1'b1;
    #1 pad_in = 1'b0;
    wpos(1'b1); wpos(1'b1); #1;
    c1_run = 1'b0;
    repeat (3) @(posedge clk);
    #1 pad_in = 1'b1;
    repeat (4) @(posedge clk);
    #1 chk("R5 io_clk0 ignored when io_clk1 selected", arr_in, 1'b0);
    c1_run = 1'b1;
    @(posedge io_clk1); #1;
    chk("R5 io_clk1 edge captures", arr_in, 1'b1);

    // R6: async clear mid-run, register
    @(negedge clk); #1;
    clk_sel = 1'b0; mode = 3'd1;
    @(posedge clk); #1;
    chk("R6 register loaded", arr_in, 1'b1);
    #1 rst_n = 1'b0; #1;
    chk("R6 register cleared without edge", arr_in, 1'b0);
    @(posedge clk); #1;
    chk("R6 register stays clear", arr_in, 1'b0);
    @(negedge clk); #1 rst_n = 1'b1;
    // R6: latch
    mode = 3'd2;
    @(posedge clk); #1;
    chk("R6 latch transparent", arr_in, 1'b1);
    rst_n = 1'b0; #1;
    chk("R6 latch cleared", arr_in, 1'b0);
    @(negedge clk); #1 rst_n = 1'b1;
    @(posedge clk); #1;

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule